// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block turns four asynchronous interrupt pins into interrupt flags for a CPU. Each pin is first brought into the clock domain, then watched by a detector whose trigger condition is set by a two-bit mode code. The two lower-numbered inputs can trigger on either edge or on either level. The two upper inputs trigger on the rising edge, the falling edge or on both edges. The highest-numbered input also passes through a digital noise-rejection filter. Its sampling rate is either every clock or once every sixteen clocks, chosen by a select input.

Flags from edge triggers stay set until software clears them. Flags in level mode follow the pin while the input is enabled. A priority stage reports whether any flag is pending and gives the fixed entry address of the pending input with the lowest address. The two upper inputs also give single-cycle count pulses to a timer. These pulses fire on the configured edge even when the interrupt itself is disabled.

Top module: `ext_irq_unit`

## Requirements
- R1: Each pin passes through a two-stage synchronizer. A rising edge on pin 0 (rising mode, enabled), applied between clock edges, shows in flag_o[0] after the third rising clock edge and not after the second.
- R2: For inputs 0 and 1, the mode code in trig_mode_i[2i+1:2i] selects the trigger: 00 = rising edge, 01 = falling edge, 10 = high level, 11 = low level.
- R3: For inputs 2 and 3, the mode code selects the trigger: 00 = rising edge, 01 = falling edge, 10 or 11 = both edges.
- R4: An edge-triggered flag stays set until its bit of flag_clr_i is high. A qualifying edge in the same cycle as a clear leaves the flag set.
- R5: A level-mode flag is high exactly while the synchronized pin is at the selected level and the input is enabled. flag_clr_i has no effect on it.
- R6: With irq_en_i[i] low, input i never sets its flag.
- R7: req_valid_o is high when any flag is set. req_vec_o gives 8'h03, 8'h0B, 8'h13 or 8'h1B for input 0, 1, 2 or 3, taking the lowest pending input, and gives 8'h00 when none is pending.
- R8: Inputs 0, 1 and 2 accept a pin pulse one clock cycle wide.
- R9: With flt_slow_i low, input 3 rejects a one-cycle pulse and accepts a pulse of two cycles.
- R10: With flt_slow_i high, input 3 rejects a 15-cycle pulse and accepts any pulse of 32 cycles or longer.
- R11: tmr_evt_o[0] and tmr_evt_o[1] give a one-cycle pulse for each edge of input 2 and input 3 that their mode code selects, whatever the enable. Two pulses on tmr_evt_o[1] are never in adjacent cycles.
- R12: While rst is high, and in the cycle after it, all flags are low, req_valid_o is low and req_vec_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous interrupt pins, bit i = input i |
| trig_mode_i | input | 8 | Two-bit trigger code per input, bits [2i+1:2i] |
| irq_en_i | input | 4 | Per-input interrupt enable |
| flt_slow_i | input | 1 | Filter sample rate for input 3: 0 = every clock, 1 = every 16 clocks |
| flag_clr_i | input | 4 | Per-input flag clear |
| flag_o | output | 4 | Interrupt flags |
| req_valid_o | output | 1 | Any flag pending |
| req_vec_o | output | 8 | Entry address of the winning input |
| tmr_evt_o | output | 2 | Timer count pulses from inputs 2 and 3 |

## Verification
On every cycle the assertions check these properties:
- flags are held until cleared on an edge-only input;
- a disabled input cannot set its flag;
- the lowest pending input wins the vector;
- the output is idle when no flag is set;
- the filtered input never gives timer pulses in adjacent cycles;
- the state after reset is correct.

Only the bench scenarios can show the following:
- the mode decoding for each input;
- the exact synchronizer latency;
- the pulse-width thresholds of the filter at both sample rates;
- the number of timer pulses for a given pin waveform;
- that clear has no effect on level flags.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NCH      = 4;
    localparam int NLVL     = 2;   // inputs below this index allow level modes
    localparam int VEC_W    = 8;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic lvl_mode;
        logic lvl_pol;
    } trg_cfg_t;

    function automatic trg_cfg_t decode_trg(logic [1:0] code, bit level_ok);
        trg_cfg_t c;
        c = '0;
        case (code)
            2'b00: c.on_rise = 1'b1;
            2'b01: c.on_fall = 1'b1;
            default: begin
                if (level_ok) begin
                    c.lvl_mode = 1'b1;
                    c.lvl_pol  = ~code[0];
                end else begin
                    c.on_rise = 1'b1;
                    c.on_fall = 1'b1;
                end
            end
        endcase
        return c;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(int unsigned idx);
        return VEC_W'(idx * 8 + 3);
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
        end else begin
            st_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/eirq_nfilt.sv
module eirq_nfilt #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic slow_i,
    output logic filt_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          smp_q;
    logic          filt_q;
    logic          strobe;

    assign strobe = !slow_i || (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            smp_q  <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            if (strobe) begin
                smp_q <= raw_i;
                if (raw_i == smp_q) filt_q <= raw_i;
            end
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import ext_irq_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_i,
    input  logic [1:0] code_i,
    input  logic       en_i,
    input  logic       clr_i,
    output logic       flag_o,
    output logic       evt_o
);
    trg_cfg_t cfg;
    logic     prev_q;
    logic     flag_q;
    logic     rise, fall;

    assign cfg   = decode_trg(code_i, LEVEL_OK);
    assign rise  = lvl_i & ~prev_q;
    assign fall  = ~lvl_i & prev_q;
    assign evt_o = (cfg.on_rise & rise) | (cfg.on_fall & fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (cfg.lvl_mode)
                flag_q <= en_i & (lvl_i == cfg.lvl_pol);
            else if (en_i & evt_o)
                flag_q <= 1'b1;
            else if (clr_i)
                flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/eirq_prio.sv
module eirq_prio
    import ext_irq_pkg::*;
(
    input  logic [NCH-1:0]   flags_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (flags_i[i]) vec_o = vec_of(i);
        end
    end

    assign valid_o = |flags_i;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int FLT_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   pin_i,
    input  logic [2*NCH-1:0] trig_mode_i,
    input  logic [NCH-1:0]   irq_en_i,
    input  logic             flt_slow_i,
    input  logic [NCH-1:0]   flag_clr_i,
    output logic [NCH-1:0]   flag_o,
    output logic             req_valid_o,
    output logic [VEC_W-1:0] req_vec_o,
    output logic [1:0]       tmr_evt_o
);
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] cond;
    logic [NCH-1:0] evt;

    eirq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == NCH - 1) begin : g_filt
            eirq_nfilt #(.DIV(FLT_DIV)) u_filt (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (pin_s[i]),
                .slow_i (flt_slow_i),
                .filt_o (cond[i])
            );
        end else begin : g_raw
            assign cond[i] = pin_s[i];
        end

        eirq_chan #(.LEVEL_OK(i < NLVL)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (cond[i]),
            .code_i (trig_mode_i[2*i +: 2]),
            .en_i   (irq_en_i[i]),
            .clr_i  (flag_clr_i[i]),
            .flag_o (flag_o[i]),
            .evt_o  (evt[i])
        );
    end

    eirq_prio u_prio (
        .flags_i (flag_o),
        .valid_o (req_valid_o),
        .vec_o   (req_vec_o)
    );

    assign tmr_evt_o = evt[NCH-1 -: 2];
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
    import ext_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   irq_en_i,
    input logic [NCH-1:0]   flag_clr_i,
    input logic [NCH-1:0]   flag_o,
    input logic             req_valid_o,
    input logic [VEC_W-1:0] req_vec_o,
    input logic [1:0]       tmr_evt_o
);
    // R4: an edge-only input keeps its flag until cleared
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_o[2] && !flag_clr_i[2]) |=> flag_o[2]);

    // R6: a disabled input never raises its flag
    p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_i[2] && !flag_o[2]) |=> !flag_o[2]);

    // R7: lowest pending input wins
    p_win0_r7: assert property (@(posedge clk) disable iff (rst)
        flag_o[0] |-> (req_vec_o == 8'h03));
    p_win1_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_o[1:0] == 2'b10) |-> (req_vec_o == 8'h0B));
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_o == '0) |-> (!req_valid_o && req_vec_o == '0));

    // R11: filtered input cannot give back-to-back timer pulses
    p_evt_gap_r11: assert property (@(posedge clk) disable iff (rst)
        tmr_evt_o[1] |=> !tmr_evt_o[1]);

    // R12: reset clears the flags
    p_reset_r12: assert property (@(posedge clk)
        rst |=> (flag_o == '0 && !req_valid_o));
endmodule

bind ext_irq_unit ext_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_en_i    (irq_en_i),
    .flag_clr_i  (flag_clr_i),
    .flag_o      (flag_o),
    .req_valid_o (req_valid_o),
    .req_vec_o   (req_vec_o),
    .tmr_evt_o   (tmr_evt_o)
);

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {mode[7:0], en[3:0], pin_a[3:0], pin_b[3:0], exp_flag[3:0], exp_vec[7:0]}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 4'hF, 4'h0, 4'hF, 4'hF, 8'h03},
        {8'h55, 4'hF, 4'hF, 4'h0, 4'hF, 8'h03},
        {8'h00, 4'h0, 4'h0, 4'hF, 4'h0, 8'h00},
        {8'hAA, 4'hF, 4'h0, 4'hF, 4'hF, 8'h03},
        {8'hAA, 4'hF, 4'hF, 4'h0, 4'hC, 8'h13},
        {8'hFF, 4'hF, 4'hF, 4'h0, 4'hF, 8'h03},
        {8'h00, 4'hA, 4'h0, 4'hF, 4'hA, 8'h0B},
        {8'h00, 4'hF, 4'h0, 4'h8, 4'h8, 8'h1B},
        {8'h01, 4'hF, 4'hF, 4'h0, 4'h1, 8'h03}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_i = '0;
    logic [7:0] trig_mode_i = '0;
    logic [3:0] irq_en_i = '0;
    logic       flt_slow_i = 1'b0;
    logic [3:0] flag_clr_i = '0;
    logic [3:0] flag_o;
    logic       req_valid_o;
    logic [7:0] req_vec_o;
    logic [1:0] tmr_evt_o;

    int checks = 0;
    int errors = 0;
    int n_evt2 = 0;
    int n_evt3 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin_i),
        .trig_mode_i (trig_mode_i),
        .irq_en_i    (irq_en_i),
        .flt_slow_i  (flt_slow_i),
        .flag_clr_i  (flag_clr_i),
        .flag_o      (flag_o),
        .req_valid_o (req_valid_o),
        .req_vec_o   (req_vec_o),
        .tmr_evt_o   (tmr_evt_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (tmr_evt_o[0]) n_evt2++;
            if (tmr_evt_o[1]) n_evt3++;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_clr_i = 4'hF;
        cyc(1);
        flag_clr_i = 4'h0;
        cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        // R12: reset state
        check("R12 flags in reset", {4'h0, flag_o}, 8'h00);
        check("R12 vec in reset", req_vec_o, 8'h00);
        rst = 1'b0;
        cyc(1);
        check("R12 valid after reset", {7'h0, req_valid_o}, 8'h00);

        // Table: R2/R3/R6/R7 trigger modes and priority
        for (int v = 0; v < NV; v++) begin
            trig_mode_i = VEC[v][31:24];
            irq_en_i    = VEC[v][23:20];
            pin_i       = VEC[v][19:16];
            cyc(8);
            clear_all();
            pin_i = VEC[v][15:12];
            cyc(8);
            check($sformatf("R2/R3/R6 flags vec%0d", v), {4'h0, flag_o}, {4'h0, VEC[v][11:8]});
            check($sformatf("R7 vector vec%0d", v), req_vec_o, VEC[v][7:0]);
            check($sformatf("R7 valid vec%0d", v), {7'h0, req_valid_o}, {7'h0, (VEC[v][11:8] != 4'h0)});
        end

        // R1: synchronizer latency
        trig_mode_i = 8'h00; irq_en_i = 4'hF; pin_i = 4'h0;
        cyc(8); clear_all();
        pin_i[0] = 1'b1;
        cyc(2);
        check("R1 flag after 2 edges", {7'h0, flag_o[0]}, 8'h00);
        cyc(1);
        check("R1 flag after 3 edges", {7'h0, flag_o[0]}, 8'h01);

        // R4: sticky flag, clear, set wins over clear
        pin_i[0] = 1'b0;
        cyc(10);
        check("R4 flag held", {7'h0, flag_o[0]}, 8'h01);
        clear_all();
        check("R4 flag cleared", {7'h0, flag_o[0]}, 8'h00);
        pin_i[0] = 1'b1;
        cyc(2);
        flag_clr_i[0] = 1'b1;
        cyc(1);
        flag_clr_i[0] = 1'b0;
        check("R4 set wins over clear", {7'h0, flag_o[0]}, 8'h01);

        // R5: level mode follows pin, clear ignored
        trig_mode_i = 8'h02; pin_i = 4'h1;
        cyc(5);
        flag_clr_i[0] = 1'b1;
        cyc(2);
        flag_clr_i[0] = 1'b0;
        check("R5 level flag ignores clear", {7'h0, flag_o[0]}, 8'h01);
        pin_i[0] = 1'b0;
        cyc(3);
        check("R5 level flag follows pin", {7'h0, flag_o[0]}, 8'h00);

        // R8 and R9: one-cycle pulses
        trig_mode_i = 8'h00; pin_i = 4'h0;
        cyc(8); clear_all();
        pin_i = 4'hF;
        cyc(1);
        pin_i = 4'h0;
        cyc(10);
        check("R8 one-cycle pulse inputs 0..2", {5'h0, flag_o[2:0]}, 8'h07);
        check("R9 one-cycle pulse rejected", {7'h0, flag_o[3]}, 8'h00);
        pin_i[3] = 1'b1;
        cyc(2);
        pin_i[3] = 1'b0;
        cyc(10);
        check("R9 two-cycle pulse accepted", {7'h0, flag_o[3]}, 8'h01);

        // R10: slow filter
        flt_slow_i = 1'b1;
        cyc(40); clear_all();
        pin_i[3] = 1'b1;
        cyc(15);
        pin_i[3] = 1'b0;
        cyc(60);
        check("R10 15-cycle pulse rejected", {7'h0, flag_o[3]}, 8'h00);
        pin_i[3] = 1'b1;
        cyc(32);
        pin_i[3] = 1'b0;
        cyc(60);
        check("R10 32-cycle pulse accepted", {7'h0, flag_o[3]}, 8'h01);
        flt_slow_i = 1'b0;

        // R11: timer events, independent of enable
        trig_mode_i = 8'h20; irq_en_i = 4'h0; pin_i = 4'h0;
        cyc(10); clear_all();
        begin
            int b2, b3;
            b2 = n_evt2; b3 = n_evt3;
            pin_i[3:2] = 2'b11;
            cyc(10);
            pin_i[3:2] = 2'b00;
            cyc(10);
            check("R11 both-edge event count input 2", 8'(n_evt2 - b2), 8'd2);
            check("R11 rising event count input 3", 8'(n_evt3 - b3), 8'd1);
            check("R11 R6 no flags while disabled", {4'h0, flag_o}, 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule